// File: doc/BRIEF.md
# Two-Channel PWM Register Controller

A memory-mapped control block for a two-channel pulse-width modulator. A host writes and reads 32-bit words over a plain single-cycle register port. Each channel has a numerically controlled oscillator driven by a 16-bit frequency word. The oscillator's carry pulses clock an 8-bit fixed-frequency PWM counter with programmable on-time and period. An output selector chooses which of the two signals reaches the channel's pin.

Per channel, a 4-bit field in a shared control word holds four bits: run, output disable, force-high and open-drain. The block drives three pad signals per channel: data out, output enable and an open-drain mode flag for the pad cell. Read data is combinational from the address. Writes take effect on the rising clock edge while the write strobe is high.

Top module: `pwm2_ctrl`

## Requirements
- R1: After reset every register reads zero, and each pad drives low with output enable high and open-drain flag low.
- R2: Registers read back what was written, with unused bits as zero. The offsets are: control 0x00, with channel c's field at bits 4c+3..4c; output-select 0x04, with channel c's bit at 4c; frequency word high byte 0x08+8c and low byte 0x0C+8c; on-time 0x18+8c; period 0x1C+8c. The last four hold 8 bits each.
- R3: Any other offset, including offsets that are not word aligned, reads zero and ignores writes.
- R4: While run (field bit 0) is clear, the channel's oscillator and counter are held cleared. The pin is driven low in push-pull mode and released (enable low) in open-drain mode.
- R5: With the disable bit (field bit 1) set, output enable is low.
- R6: With run and force-high (field bit 2) set, the channel's logic output is high whatever the selector and generators do.
- R7: With open-drain (field bit 3) set, data out is zero and output enable is high exactly when the logic output is low and the disable bit is clear.
- R8: With the select bit clear, the pin carries the oscillator's accumulator MSB. For a word W that is a power of two, this is a 50% square wave with a period of 65536/W clocks.
- R9: With the select bit set, the pin carries the PWM signal. One PWM period is P+1 oscillator carries and the signal is high for min(ON, P+1) of them, so ON > P gives a constant high. After the period is lowered, the counter wraps at the next carry.
- R10: The two channels are independent. Channel 1 uses its own control field, select bit and per-channel registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 8 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| pad_do_o | output | 2 | Pad data out per channel |
| pad_oe_o | output | 2 | Pad output enable per channel |
| pad_od_o | output | 2 | Pad open-drain mode per channel |

## Verification
Two things can fall in the same cycle: a host write that shortens the period or changes the frequency word, and a carry that advances the PWM counter from its old value. The random phase reprograms running channels at arbitrary phases, so the counter can sit above the new period when the write lands. After a settling interval, the bench judges the result by counting high cycles over a window of whole PWM periods. The directed cases set force-high and disable in the same write, and each pad signal is checked separately.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
  localparam int NUM_CH    = 2;
  localparam int FLD_W     = 4;
  localparam int CW_W      = 16;
  localparam int PV_W      = 8;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 32;
  localparam int CH_STRIDE = 8;
  // byte offsets
  localparam int OFF_CTRL  = 'h00;
  localparam int OFF_SEL   = 'h04;
  localparam int OFF_CW_HI = 'h08;
  localparam int OFF_CW_LO = 'h0C;
  localparam int OFF_ON    = 'h18;
  localparam int OFF_PER   = 'h1C;
  // bit positions inside a channel field
  localparam int B_RUN     = 0;
  localparam int B_DIS     = 1;
  localparam int B_FRC     = 2;
  localparam int B_OD      = 3;
endpackage

// File: rtl/pwm2_regs.sv
module pwm2_regs
  import pwm2_pkg::*;
(
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               wr_en_i,
  input  logic [ADDR_W-1:0]                  addr_i,
  input  logic [DATA_W-1:0]                  wdata_i,
  output logic [DATA_W-1:0]                  rdata_o,
  output logic [NUM_CH-1:0][FLD_W-1:0]       ctrl_o,
  output logic [NUM_CH-1:0]                  sel_o,
  output logic [NUM_CH-1:0][CW_W-1:0]        cw_o,
  output logic [NUM_CH-1:0][PV_W-1:0]        on_o,
  output logic [NUM_CH-1:0][PV_W-1:0]        per_o
);
  localparam int HALF_W = CW_W / 2;

  logic [NUM_CH-1:0][FLD_W-1:0]  ctrl_q;
  logic [NUM_CH-1:0]             sel_q;
  logic [NUM_CH-1:0][HALF_W-1:0] hi_q, lo_q;
  logic [NUM_CH-1:0][PV_W-1:0]   on_q, per_q;

  logic              dec_ctrl, dec_sel, hit;
  logic [NUM_CH-1:0] dec_hi, dec_lo, dec_on, dec_per;
  logic [DATA_W-1:0] rdata;

  wire unused_wdata = ^wdata_i[DATA_W-1:FLD_W*NUM_CH];

  always_comb begin
    dec_ctrl = (addr_i == ADDR_W'(OFF_CTRL));
    dec_sel  = (addr_i == ADDR_W'(OFF_SEL));
    rdata    = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      dec_hi[c]  = (addr_i == ADDR_W'(OFF_CW_HI + CH_STRIDE*c));
      dec_lo[c]  = (addr_i == ADDR_W'(OFF_CW_LO + CH_STRIDE*c));
      dec_on[c]  = (addr_i == ADDR_W'(OFF_ON    + CH_STRIDE*c));
      dec_per[c] = (addr_i == ADDR_W'(OFF_PER   + CH_STRIDE*c));
      if (dec_ctrl)  rdata[FLD_W*c +: FLD_W] = ctrl_q[c];
      if (dec_sel)   rdata[FLD_W*c]          = sel_q[c];
      if (dec_hi[c]) rdata[HALF_W-1:0]       = hi_q[c];
      if (dec_lo[c]) rdata[HALF_W-1:0]       = lo_q[c];
      if (dec_on[c]) rdata[PV_W-1:0]         = on_q[c];
      if (dec_per[c]) rdata[PV_W-1:0]        = per_q[c];
    end
    hit = dec_ctrl | dec_sel | (|dec_hi) | (|dec_lo) | (|dec_on) | (|dec_per);
  end

  assign rdata_o = rdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      sel_q  <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      on_q   <= '0;
      per_q  <= '0;
    end else if (wr_en_i) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (dec_ctrl)   ctrl_q[c] <= wdata_i[FLD_W*c +: FLD_W];
        if (dec_sel)    sel_q[c]  <= wdata_i[FLD_W*c];
        if (dec_hi[c])  hi_q[c]   <= wdata_i[HALF_W-1:0];
        if (dec_lo[c])  lo_q[c]   <= wdata_i[HALF_W-1:0];
        if (dec_on[c])  on_q[c]   <= wdata_i[PV_W-1:0];
        if (dec_per[c]) per_q[c]  <= wdata_i[PV_W-1:0];
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_out
    assign cw_o[c] = {hi_q[c], lo_q[c]};
  end
  assign ctrl_o = ctrl_q;
  assign sel_o  = sel_q;
  assign on_o   = on_q;
  assign per_o  = per_q;

  // R3: a write that hits nothing leaves every register unchanged
  p_unmapped_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !hit) |=> ($stable(ctrl_q) && $stable(sel_q) && $stable(hi_q)
                           && $stable(lo_q) && $stable(on_q) && $stable(per_q)));
endmodule

// File: rtl/pwm2_nco.sv
module pwm2_nco
  import pwm2_pkg::*;
#(
  parameter int W = CW_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] cw_i,
  output logic         fout_o,
  output logic         tick_o
);
  logic [W-1:0] acc_q;
  logic [W-1:0] sum;
  logic         carry, tick_q;

  assign {carry, sum} = {1'b0, acc_q} + {1'b0, cw_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (!en_i) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= sum;
      tick_q <= carry;
    end
  end

  assign fout_o = acc_q[W-1];
  assign tick_o = tick_q;

  // R4: a stopped oscillator is cleared one cycle later
  p_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!fout_o && !tick_o));
endmodule

// File: rtl/pwm2_fixed.sv
module pwm2_fixed
  import pwm2_pkg::*;
#(
  parameter int W = PV_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic [W-1:0] on_i,
  input  logic [W-1:0] per_i,
  output logic         out_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_i)  cnt_q <= (cnt_q >= per_i) ? '0 : cnt_q + 1'b1;
  end

  assign out_o = en_i && (cnt_q < on_i);

  // R9: a carry at or beyond the period returns the counter to zero
  p_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && cnt_q >= per_i) |=> (cnt_q == '0));
  // R9: without a carry the counter holds
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pwm2_chan.sv
module pwm2_chan
  import pwm2_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [FLD_W-1:0] ctrl_i,
  input  logic             sel_i,
  input  logic [CW_W-1:0]  cw_i,
  input  logic [PV_W-1:0]  on_i,
  input  logic [PV_W-1:0]  per_i,
  output logic             pad_do_o,
  output logic             pad_oe_o,
  output logic             pad_od_o
);
  logic run, dis, frc, od;
  logic nco_out, nco_tick, pwm_out, sig;

  assign run = ctrl_i[B_RUN];
  assign dis = ctrl_i[B_DIS];
  assign frc = ctrl_i[B_FRC];
  assign od  = ctrl_i[B_OD];

  pwm2_nco #(.W(CW_W)) u_nco (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(run), .cw_i(cw_i),
    .fout_o(nco_out), .tick_o(nco_tick)
  );

  pwm2_fixed #(.W(PV_W)) u_fix (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(run), .tick_i(nco_tick),
    .on_i(on_i), .per_i(per_i), .out_o(pwm_out)
  );

  always_comb begin
    if (!run)      sig = 1'b0;
    else if (frc)  sig = 1'b1;
    else if (sel_i) sig = pwm_out;
    else           sig = nco_out;
  end

  // open-drain: only a driven low; stopped channel is released
  assign pad_do_o = od ? 1'b0 : sig;
  assign pad_oe_o = !dis && (od ? (run && !sig) : 1'b1);
  assign pad_od_o = od;

  // R5
  p_dis_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis |-> !pad_oe_o);
  // R7
  p_od_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    od |-> (!pad_do_o && (pad_oe_o == (!dis && run && !sig))));
  // R6
  p_force_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && frc && !od) |-> pad_do_o);
  // R4
  p_stop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> (!pad_do_o && (!od || !pad_oe_o) && !pwm_out));
endmodule

// File: rtl/pwm2_ctrl.sv
module pwm2_ctrl
  import pwm2_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [7:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [1:0]        pad_do_o,
  output logic [1:0]        pad_oe_o,
  output logic [1:0]        pad_od_o
);
  logic [NUM_CH-1:0][FLD_W-1:0] ctrl;
  logic [NUM_CH-1:0]            sel;
  logic [NUM_CH-1:0][CW_W-1:0]  cw;
  logic [NUM_CH-1:0][PV_W-1:0]  on_v, per_v;

  pwm2_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ctrl_o(ctrl), .sel_o(sel),
    .cw_o(cw), .on_o(on_v), .per_o(per_v)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm2_chan u_ch (
      .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_i(ctrl[c]), .sel_i(sel[c]),
      .cw_i(cw[c]), .on_i(on_v[c]), .per_i(per_v[c]),
      .pad_do_o(pad_do_o[c]), .pad_oe_o(pad_oe_o[c]), .pad_od_o(pad_od_o[c])
    );
  end
endmodule

// File: tb/sim_pwm2_ctrl.sv
module sim_pwm2_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  pad_do, pad_oe, pad_od;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm2_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pad_do_o(pad_do), .pad_oe_o(pad_oe), .pad_od_o(pad_od)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] sh [64];

  function automatic logic [31:0] msk(int a);
    if (a == 0) return 32'hFF;
    if (a == 4) return 32'h11;
    if (a >= 8 && a <= 36 && (a % 4) == 0) return 32'hFF;
    return 32'h0;
  endfunction

  // high clocks in a window of 4 PWM periods, s clocks per carry
  function automatic int exp_high(int s, int p, int on);
    int d;
    d = (on < p + 1) ? on : p + 1;
    return 4 * s * d;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 8'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a >= 0 && a < 64) sh[a] = d & msk(a);
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    addr = 8'(a);
    #1 d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic meas(int ch, int n, output int hd, output int ho, output int rs);
    logic prev;
    hd = 0; ho = 0; rs = 0;
    @(negedge clk);
    prev = pad_do[ch];
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pad_do[ch]) hd++;
      if (pad_oe[ch]) ho++;
      if (pad_do[ch] && !prev) rs++;
      prev = pad_do[ch];
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int hd, ho, rs;
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) sh[i] = '0;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    for (int a = 0; a < 40; a += 4) begin
      rd(a, d); chk("R1 reset reg", d, 0);
    end
    chk("R1 reset do", pad_do, 2'b00);
    chk("R1 reset oe", pad_oe, 2'b11);
    chk("R1 reset od", pad_od, 2'b00);

    // R2 readback with masking
    wr('h00, 32'hFFFF_FFFF); rd('h00, d); chk("R2 ctrl mask", d, 32'hFF);
    wr('h04, 32'hFFFF_FFFF); rd('h04, d); chk("R2 sel mask", d, 32'h11);
    wr('h1C, 32'hABCD_1234); rd('h1C, d); chk("R2 period ch0", d, 32'h34);
    wr('h14, 32'h0000_01A5); rd('h14, d); chk("R2 cw lo ch1", d, 32'hA5);
    wr('h00, 0);

    // R3 unmapped and unaligned
    wr('h28, 32'hFFFF_FFFF); rd('h28, d); chk("R3 unmapped 0x28", d, 0);
    wr('h09, 32'hFFFF_FFFF); rd('h09, d); chk("R3 unaligned 0x09", d, 0);
    rd('h08, d); chk("R3 neighbour 0x08 kept", d, 0);
    rd('h1C, d); chk("R3 period unchanged", d, 32'h34);

    // R2 R3 random writes against shadow
    for (int i = 0; i < 80; i++) wr(int'($urandom % 64), $urandom);
    for (int a = 0; a < 64; a++) begin
      rd(a, d); chk($sformatf("R2 R3 random read 0x%0h", a), d, sh[a]);
    end
    for (int a = 0; a < 40; a += 4) wr(a, 0);

    // R4 stopped open-drain releases, push-pull drives low
    wr('h00, 32'h08); idle(4);
    chk("R4 stopped od oe", pad_oe[0], 0);
    chk("R4 stopped od do", pad_do[0], 0);
    chk("R4 stopped pp oe ch1", pad_oe[1], 1);

    // R8 raw oscillator, W=0x2000 -> period 8
    wr('h08, 32'h20); wr('h0C, 0); wr('h04, 0); wr('h00, 32'h01);
    idle(40); meas(0, 64, hd, ho, rs);
    chk("R8 raw high count", hd, 32);
    chk("R8 raw rising edges", rs, 8);

    // R9 PWM with W=0x8000 (carry every 2 clocks)
    wr('h08, 32'h80); wr('h04, 32'h01); wr('h18, 3); wr('h1C, 7);
    idle(100); meas(0, 64, hd, ho, rs);
    chk("R9 on3 per7 high", hd, exp_high(2, 7, 3));
    wr('h18, 9); idle(100); meas(0, 64, hd, ho, rs);
    chk("R9 on>per constant high", hd, 64);
    wr('h18, 0); idle(100); meas(0, 64, hd, ho, rs);
    chk("R9 on0 never high", hd, 0);

    // R9 random reprogramming while running
    for (int i = 0; i < 8; i++) begin
      int k, s, p, on;
      k = int'($urandom % 3); s = 2 << k;
      p = 1 + int'($urandom % 15); on = int'($urandom % (p + 3));
      wr('h08, 32'((65536 / s) >> 8)); wr('h1C, 32'(p)); wr('h18, 32'(on));
      idle(300); meas(0, s * (p + 1) * 4, hd, ho, rs);
      chk($sformatf("R9 random s%0d p%0d on%0d", s, p, on), hd, exp_high(s, p, on));
    end

    // R6 force overrides PWM at on=0
    wr('h08, 32'h80); wr('h18, 0); wr('h1C, 7);
    wr('h00, 32'h05); idle(20); meas(0, 32, hd, ho, rs);
    chk("R6 force high", hd, 32);
    // R5 disable with force in the same write
    wr('h00, 32'h07); idle(4); meas(0, 32, hd, ho, rs);
    chk("R5 disable oe low", ho, 0);
    chk("R6 force still drives data", hd, 32);

    // R7 open-drain PWM on3 per7
    wr('h18, 3); wr('h00, 32'h09); idle(100); meas(0, 64, hd, ho, rs);
    chk("R7 od data never high", hd, 0);
    chk("R7 od enable when low", ho, 64 - exp_high(2, 7, 3));

    // R10 channel 1 alone
    wr('h00, 32'h10); wr('h04, 32'h10); wr('h10, 32'h80); wr('h14, 0);
    wr('h20, 2); wr('h24, 3); idle(100);
    meas(1, 32, hd, ho, rs); chk("R10 ch1 pwm high", hd, exp_high(2, 3, 2));
    meas(0, 32, hd, ho, rs); chk("R10 ch0 stays low", hd, 0);
    chk("R10 ch0 oe while stopped pp", ho, 32);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule